// File: doc/BRIEF.md
# Triggered Sequence Repeat Controller

This block decides when a stored transfer sequence is launched again. A host writes a control word made of a start bit, an abort-stop bit, a stop-at-end bit and a trigger-mode bit, along with a frame count and an interval length. The block then sends one-cycle launch pulses to the sequencer that plays the stored sequence. The sequencer answers with a done pulse at the end of each replay.

There are two pacing modes. In trigger mode, each rising edge on an external trigger pin starts one replay, and the block keeps replaying until the host stops it. In timer mode, replays are separated by a programmable idle interval, and a frame counter ends the run after a set number of replays.

A stop request aborts the replay in progress. A stop-at-end request lets the current replay finish first. Both kinds of stop are discarded when the block is not running.

Top module: `seq_repeat_ctrl`

## Requirements
- R1: With trigger mode on and the block running, a rising edge on `trig_in` gives a one-cycle `seq_start` pulse. The pulse is seen at the third rising clock edge after `trig_in` goes high: two synchroniser stages, then the output register.
- R2: With trigger mode off, `trig_in` has no effect on `seq_start`.
- R3: A host write sets the trigger-mode bit only while `running` is 0. While running, writes leave `trig_mode` unchanged.
- R4: In trigger mode the frame count is ignored. Replays continue after any number of done pulses until a stop request arrives.
- R5: A trigger edge that is detected in the same cycle as the write that sets the start bit is discarded. Only a later trigger edge launches a replay.
- R6: A trigger edge that arrives while a replay is in progress (`seq_active` = 1) is dropped and is not queued.
- R7: Stop and stop-at-end bits written while `running` is 0 are discarded. They do not prevent a start carried in the same or a later write.
- R8: An accepted stop request clears `running` and `seq_active` at the next edge. It gives a one-cycle `seq_abort` pulse if a replay was in progress. When stop and stop-at-end are requested together, stop takes priority.
- R9: An accepted stop-at-end request blocks further launches and clears `running` on the done pulse of the current replay. If no replay is in progress, it clears `running` at the next edge.
- R10: In timer mode, the first `seq_start` follows one edge after the edge that takes the start write. Each later `seq_start` comes I+1 edges after the edge that takes `seq_done`, where I is the interval captured at the start write.
- R11: In timer mode, a frame count of N gives exactly N replays, with 0 treated as 1. `running` falls on the edge that takes the N-th done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host control write strobe |
| host_start | input | 1 | Start bit of the write |
| host_stop | input | 1 | Abort-stop bit of the write |
| host_stop_seq | input | 1 | Stop-at-end bit of the write |
| host_trig_en | input | 1 | Trigger-mode bit of the write |
| host_frames | input | FRAME_W | Replay count for timer mode, captured on start |
| host_interval | input | TIMER_W | Idle cycles between replays in timer mode, captured on start |
| trig_in | input | 1 | Asynchronous external trigger |
| seq_done | input | 1 | Sequencer finished the current replay |
| seq_start | output | 1 | One-cycle replay launch pulse |
| seq_abort | output | 1 | One-cycle abort pulse to the sequencer |
| running | output | 1 | Start bit state |
| trig_mode | output | 1 | Trigger-mode state |
| seq_active | output | 1 | A replay is in progress |

## Verification
All inputs are driven on the falling edge, and every output is read on a later falling edge. Because of this, each latency can be counted in whole edges: one edge for state changes caused by a write, three edges for a trigger, and I+1 edges from a done pulse to the next timer launch.

The bench counts falling edges from each stimulus to the first `seq_start`, and compares that count with the figure worked out from the requirement. Negative cases watch `seq_start` through a window that is longer than its longest legal latency.

The timer mode is swept over every combination of frame count and interval from 0 to 3.

// File: rtl/seq_repeat_pkg.sv
package seq_repeat_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_ABORT = 2'd2,
    CMD_DRAIN = 2'd3
  } cmd_kind_e;

  // Classify one host write; stop outranks stop-at-end, both need running.
  function automatic cmd_kind_e classify_cmd(input logic wr, input logic start,
                                             input logic stop, input logic stop_seq,
                                             input logic is_running);
    cmd_kind_e k;
    k = CMD_NONE;
    if (wr) begin
      if (!is_running) begin
        if (start) k = CMD_START;
      end else if (stop) begin
        k = CMD_ABORT;
      end else if (stop_seq) begin
        k = CMD_DRAIN;
      end
    end
    return k;
  endfunction

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] period_in,
  input  logic         clear,
  input  logic         restart,
  output logic         expired
);
  logic [W-1:0] period_q;
  logic [W-1:0] count_q;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      count_q  <= '0;
    end else begin
      if (capture) period_q <= period_in;
      if (clear)        count_q <= '0;
      else if (restart) count_q <= period_q;
      else              count_q <= step_down(count_q);
    end
  end

  assign expired = (count_q == '0);
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] frames_in,
  input  logic         dec,
  output logic         empty
);
  logic [W-1:0] left_q;

  function automatic logic [W-1:0] replay_total(input logic [W-1:0] f);
    return (f == '0) ? {{(W-1){1'b0}}, 1'b1} : f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left_q <= '0;
    else if (load)                   left_q <= replay_total(frames_in);
    else if (dec && left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign empty = (left_q == '0);
endmodule

// File: rtl/seq_repeat_ctrl.sv
module seq_repeat_ctrl
  import seq_repeat_pkg::*;
#(
  parameter int FRAME_W     = 6,
  parameter int TIMER_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_start,
  input  logic               host_stop,
  input  logic               host_stop_seq,
  input  logic               host_trig_en,
  input  logic [FRAME_W-1:0] host_frames,
  input  logic [TIMER_W-1:0] host_interval,
  input  logic               trig_in,
  input  logic               seq_done,
  output logic               seq_start,
  output logic               seq_abort,
  output logic               running,
  output logic               trig_mode,
  output logic               seq_active
);
  cmd_kind_e cmd;
  logic run_q, te_q, active_q, stop_pend_q, start_q, abort_q;
  logic start_evt, abort_evt, drain_evt, done_evt;
  logic trig_rise, timer_expired, frames_empty;
  logic pace_ok, launch, go_idle;

  assign cmd       = classify_cmd(host_wr, host_start, host_stop, host_stop_seq, run_q);
  assign start_evt = (cmd == CMD_START);
  assign abort_evt = (cmd == CMD_ABORT);
  assign drain_evt = (cmd == CMD_DRAIN);
  assign done_evt  = seq_done & active_q;

  trig_edge_detect #(.STAGES(SYNC_STAGES)) u_trig (
    .clk (clk), .rst_n (rst_n), .din (trig_in), .rise (trig_rise)
  );

  interval_timer #(.W(TIMER_W)) u_timer (
    .clk (clk), .rst_n (rst_n), .capture (start_evt), .period_in (host_interval),
    .clear (start_evt), .restart (done_evt), .expired (timer_expired)
  );

  frame_counter #(.W(FRAME_W)) u_frames (
    .clk (clk), .rst_n (rst_n), .load (start_evt), .frames_in (host_frames),
    .dec (launch & ~te_q), .empty (frames_empty)
  );

  // Pacing source: trigger edge in trigger mode, expired interval otherwise.
  assign pace_ok = te_q ? trig_rise : timer_expired;
  assign launch  = run_q & ~active_q & ~stop_pend_q & ~abort_evt & ~drain_evt & pace_ok;

  assign go_idle = abort_evt
                 | (drain_evt & (~active_q | done_evt))
                 | (done_evt & (stop_pend_q | (~te_q & frames_empty)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      te_q        <= 1'b0;
      active_q    <= 1'b0;
      stop_pend_q <= 1'b0;
      start_q     <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      if (start_evt)    run_q <= 1'b1;
      else if (go_idle) run_q <= 1'b0;

      if (host_wr && !run_q) te_q <= host_trig_en;

      if (launch)                      active_q <= 1'b1;
      else if (abort_evt || done_evt)  active_q <= 1'b0;

      if (go_idle || start_evt) stop_pend_q <= 1'b0;
      else if (drain_evt)       stop_pend_q <= 1'b1;

      start_q <= launch;
      abort_q <= abort_evt & active_q;
    end
  end

  assign seq_start  = start_q;
  assign seq_abort  = abort_q;
  assign running    = run_q;
  assign trig_mode  = te_q;
  assign seq_active = active_q;
endmodule

// File: rtl/seq_repeat_ctrl_checker.sv
module seq_repeat_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic host_start,
  input logic host_stop,
  input logic host_stop_seq,
  input logic seq_done,
  input logic seq_start,
  input logic seq_abort,
  input logic running,
  input logic trig_mode,
  input logic seq_active
);
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  assert_te_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && host_wr) |=> (trig_mode == $past(trig_mode)));

  assert_start_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_start && !running) |=> !seq_start);

  assert_no_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !$past(seq_active));

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_stop || host_stop_seq) && !host_start && !running) |=> !running);

  assert_stop_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_stop && host_stop_seq && running && seq_active)
      |=> (seq_abort && !running && !seq_active));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_stop_seq && !host_stop && running && seq_active && !seq_done)
      |=> (running && !seq_start && !seq_abort));
endmodule

bind seq_repeat_ctrl seq_repeat_ctrl_checker u_checker (
  .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_start (host_start),
  .host_stop (host_stop), .host_stop_seq (host_stop_seq), .seq_done (seq_done),
  .seq_start (seq_start), .seq_abort (seq_abort), .running (running),
  .trig_mode (trig_mode), .seq_active (seq_active)
);

// File: tb/seq_repeat_ctrl_bench.sv
module seq_repeat_ctrl_bench;
  localparam int FW = 6;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_start = 1'b0, host_stop = 1'b0, host_stop_seq = 1'b0;
  logic host_trig_en = 1'b0;
  logic [FW-1:0] host_frames = '0;
  logic [TW-1:0] host_interval = '0;
  logic trig_in = 1'b0, seq_done = 1'b0;
  logic seq_start, seq_abort, running, trig_mode, seq_active;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  seq_repeat_ctrl #(.FRAME_W(FW), .TIMER_W(TW), .SYNC_STAGES(2)) u_seq_repeat_ctrl (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_start (host_start),
    .host_stop (host_stop), .host_stop_seq (host_stop_seq), .host_trig_en (host_trig_en),
    .host_frames (host_frames), .host_interval (host_interval), .trig_in (trig_in),
    .seq_done (seq_done), .seq_start (seq_start), .seq_abort (seq_abort),
    .running (running), .trig_mode (trig_mode), .seq_active (seq_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic st, input logic sp, input logic ss, input logic te,
                    input int fr, input int iv);
    host_start = st; host_stop = sp; host_stop_seq = ss; host_trig_en = te;
    host_frames = FW'(fr); host_interval = TW'(iv);
    host_wr = 1'b1;
    tick();
    host_wr = 1'b0; host_start = 1'b0; host_stop = 1'b0; host_stop_seq = 1'b0;
  endtask

  task automatic done_pulse();
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!seq_start && n < 40);
  endtask

  // Trigger pulse: at3 = seq_start on third falling edge, any = seen in window.
  task automatic pulse_trig(output logic at3, output logic any);
    any = 1'b0;
    at3 = 1'b0;
    trig_in = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      if (i == 3) at3 = seq_start;
      any = any | seq_start;
      if (i == 3) trig_in = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int expn;
    logic a3, any;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("reset", "running", int'(running), 0);
    chk("reset", "seq_start", int'(seq_start), 0);
    chk("reset", "seq_active", int'(seq_active), 0);
    chk("reset", "trig_mode", int'(trig_mode), 0);

    // R10 / R11 sweep over frame count and interval in timer mode
    for (int fr = 0; fr < 4; fr++) begin
      for (int iv = 0; iv < 4; iv++) begin
        wr(1'b1, 1'b0, 1'b0, 1'b0, fr, iv);
        chk("R10", "running after start", int'(running), 1);
        expn = (fr == 0) ? 1 : fr;
        for (int k = 0; k < expn; k++) begin
          wait_start(n);
          chk("R10", "start latency", n, (k == 0) ? 1 : iv + 1);
          chk("R10", "active with start", int'(seq_active), 1);
          tick();
          chk("R1", "start is one cycle", int'(seq_start), 0);
          done_pulse();
          chk("R11", "running after done", int'(running), (k == expn - 1) ? 0 : 1);
        end
        repeat (4) tick();
        chk("R11", "no extra replay", int'(seq_start), 0);
      end
    end

    // R3: trigger-mode bit written while idle
    wr(1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
    chk("R3", "te set while idle", int'(trig_mode), 1);
    chk("R3", "no start without start bit", int'(running), 0);
    wr(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R3", "te cleared while idle", int'(trig_mode), 0);

    // R2: trigger ignored in timer mode
    wr(1'b1, 1'b0, 1'b0, 1'b0, 3, 30);
    wait_start(n);
    chk("R10", "first start", n, 1);
    tick();
    done_pulse();
    pulse_trig(a3, any);
    chk("R2", "trigger ignored", int'(any), 0);
    wr(1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
    chk("R8", "stop between replays", int'(running), 0);
    chk("R8", "no abort when not active", int'(seq_abort), 0);
    tick();

    // R5: trigger edge coinciding with the start write is discarded
    trig_in = 1'b1;
    tick(); tick();
    wr(1'b1, 1'b0, 1'b0, 1'b1, 1, 0);
    any = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      any = any | seq_start;
    end
    trig_in = 1'b0;
    tick(); tick();
    chk("R5", "blanked trigger", int'(any), 0);
    chk("R5", "still running", int'(running), 1);
    pulse_trig(a3, any);
    chk("R1", "trigger start at third edge", int'(a3), 1);

    // R6: trigger during active replay dropped
    pulse_trig(a3, any);
    chk("R6", "trigger while active", int'(any), 0);
    done_pulse();
    repeat (3) tick();
    chk("R6", "no queued start", int'(seq_start), 0);

    // R4: frame count ignored in trigger mode (frames = 1)
    for (int r = 0; r < 3; r++) begin
      pulse_trig(a3, any);
      chk("R4", "trigger replay", int'(a3), 1);
      done_pulse();
      chk("R4", "running after done", int'(running), 1);
    end

    // R3: te frozen while running
    wr(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R3", "te frozen", int'(trig_mode), 1);
    wr(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R3", "te frozen on start", int'(trig_mode), 1);

    // R8: stop with stop-at-end during active replay
    pulse_trig(a3, any);
    chk("R1", "trigger start", int'(a3), 1);
    wr(1'b0, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R8", "running cleared", int'(running), 0);
    chk("R8", "abort pulse", int'(seq_abort), 1);
    chk("R8", "active cleared", int'(seq_active), 0);
    tick();
    chk("R8", "abort one cycle", int'(seq_abort), 0);

    // R7: stops discarded while idle
    wr(1'b0, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R7", "idle stop ignored", int'(running), 0);
    wr(1'b1, 1'b1, 1'b0, 1'b1, 0, 0);
    chk("R7", "start with stop bit", int'(running), 1);
    pulse_trig(a3, any);
    chk("R7", "start not cancelled", int'(a3), 1);

    // R9: stop-at-end during active replay
    wr(1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
    chk("R9", "still running", int'(running), 1);
    chk("R9", "still active", int'(seq_active), 1);
    chk("R9", "no abort", int'(seq_abort), 0);
    pulse_trig(a3, any);
    chk("R9", "no launch while draining", int'(any), 0);
    done_pulse();
    chk("R9", "idle after done", int'(running), 0);

    // R9: stop-at-end between replays
    wr(1'b1, 1'b0, 1'b0, 1'b1, 0, 0);
    wr(1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
    chk("R9", "idle at once", int'(running), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule